// File: doc/BRIEF.md
# Physical Register Rename Stage with Free List

This block is the rename stage of an out-of-order core that keeps all register values, committed and speculative, in one physical register file. It looks up each instruction's architectural source registers in a mapping table and returns physical register numbers. No register values pass through it. For an instruction that writes a register, it takes a fresh physical register from a FIFO free list, points the destination's table entry at it, and reports the mapping it replaced.

Every renamed instruction is recorded in an in-flight log as the tuple (writes-a-register, architectural destination, new physical, previous physical). Commit retires the oldest log entry and returns its previous physical register to the free list, because that register can only go back into use once the next writer of the same architectural register has committed. A trap starts a recovery walk. The walk undoes the in-flight log one entry per cycle, youngest first. Each undo writes the saved previous mapping back into the table and returns the new physical register to the free list.

The rename port is valid/ready. A request is accepted on a cycle where both `rn_valid` and `rn_ready` are high. The response fields (`rn_psrc1`, `rn_psrc2`, `rn_pdst`, `rn_pold`) are combinational and are valid in that same cycle. The requester must hold its request stable until it is accepted. `rn_ready` may depend on `rn_has_dst`. The commit port follows the same rule with `cmt_valid`/`cmt_ready`. `trap` is a plain one-cycle pulse and `recover_busy` is a plain status level.

Top module: `rf_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, the free list holds physical registers NUM_ARCH up to NUM_PHYS-1 in ascending order, `recover_busy` is low, `cmt_ready` is low and `rn_ready` is high.
- R2: Each source is translated through the current mapping table, and only register numbers are returned. A source equal to the same instruction's destination gets the mapping from before that instruction.
- R3: An accepted instruction with a destination is given the free-list head as `rn_pdst`, and later instructions reading that architectural register see the new physical register.
- R4: `rn_pold` is the mapping the destination architectural register had just before the instruction was accepted.
- R5: An instruction without a destination takes nothing from the free list and leaves the table unchanged. On commit it returns nothing (`cmt_frees` low).
- R6: `rn_ready` is low while the free list is empty and `rn_has_dst` is high, while the in-flight log is full, during recovery, and in a cycle where `trap` is high. An instruction without a destination can still be accepted while the free list is empty.
- R7: Commit retires log entries oldest first. An accepted commit of an entry with a destination presents that entry's previous physical register on `cmt_old_preg` with `cmt_frees` high, and appends it to the tail of the free list. `cmt_ready` is low when nothing is in flight.
- R8: A trap with N in-flight entries holds `recover_busy` high for exactly N cycles, starting the cycle after the trap. Afterwards every architectural register maps as it did before the oldest in-flight instruction. A trap with nothing in flight does nothing.
- R9: Each undone entry with a destination appends its new physical register to the free-list tail, youngest entry first. The free list never holds more than NUM_PHYS-NUM_ARCH registers.
- R10: While `recover_busy` is high, `rn_ready` and `cmt_ready` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request present |
| rn_ready | output | 1 | Rename request can be accepted this cycle |
| rn_src1 | input | $clog2(NUM_ARCH) | First architectural source |
| rn_src2 | input | $clog2(NUM_ARCH) | Second architectural source |
| rn_has_dst | input | 1 | Instruction writes a register |
| rn_dst | input | $clog2(NUM_ARCH) | Architectural destination |
| rn_psrc1 | output | $clog2(NUM_PHYS) | Physical register for the first source |
| rn_psrc2 | output | $clog2(NUM_PHYS) | Physical register for the second source |
| rn_pdst | output | $clog2(NUM_PHYS) | Newly allocated physical destination (0 when there is no destination) |
| rn_pold | output | $clog2(NUM_PHYS) | Previous mapping of the destination (0 when there is no destination) |
| cmt_valid | input | 1 | Oldest in-flight instruction commits |
| cmt_ready | output | 1 | Commit can be accepted this cycle |
| cmt_frees | output | 1 | The oldest entry returns a register when it commits |
| cmt_old_preg | output | $clog2(NUM_PHYS) | Physical register that the oldest entry returns |
| trap | input | 1 | Pulse that discards all in-flight instructions |
| recover_busy | output | 1 | Undo walk in progress |

## Verification
The first pattern is a chain of writes to one architectural register, mixed with reads of it. It separates a table update that later readers see from a stale read, and it shows whether a source equal to its own instruction's destination gets the old mapping. The second pattern puts destination-less instructions between writers. It catches any allocation, table change or release that such instructions should not cause. The third pattern drains the free list and then commits. It shows whether stalls depend on whether the instruction writes a register, and whether released registers return in FIFO order behind the untouched ones. The last pattern is a trap with mixed entries in flight. The trap is checked through the walk length, the restored source translations, and the youngest-first order in which new registers reappear from the free list.

// File: rtl/rf_rename_pkg.sv
package rf_rename_pkg;
  typedef enum logic {
    RS_RUN  = 1'b0,
    RS_UNDO = 1'b1
  } rec_state_e;
endpackage

// File: rtl/rf_freelist.sv
// FIFO of free physical register numbers; reset fills it with the
// registers above the initial identity mapping, in ascending order.
module rf_freelist #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pop,
  input  logic                        push,
  input  logic [$clog2(NUM_PHYS)-1:0] push_preg,
  output logic [$clog2(NUM_PHYS)-1:0] head_preg,
  output logic                        empty,
  output logic [$clog2(NUM_PHYS):0]   count
);
  localparam int PW    = $clog2(NUM_PHYS);
  localparam int NFREE = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0] slots [NUM_PHYS];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;

  assign head_preg = slots[rd_ptr];
  assign empty     = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        slots[i] <= (i < NFREE) ? PW'(NUM_ARCH + i) : '0;
      end
      rd_ptr <= '0;
      wr_ptr <= PW'(NFREE);
      count  <= (PW+1)'(NFREE);
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_preg;
        wr_ptr        <= wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
      if (push && !pop) begin
        count <= count + 1'b1;
      end else if (pop && !push) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_maptable.sv
// Architectural-to-physical mapping with three read ports
// (two sources plus the destination's prior mapping) and one write port.
module rf_maptable #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NUM_ARCH)-1:0] rd_a1,
  input  logic [$clog2(NUM_ARCH)-1:0] rd_a2,
  input  logic [$clog2(NUM_ARCH)-1:0] rd_a3,
  output logic [$clog2(NUM_PHYS)-1:0] rd_p1,
  output logic [$clog2(NUM_PHYS)-1:0] rd_p2,
  output logic [$clog2(NUM_PHYS)-1:0] rd_p3,
  input  logic                        we,
  input  logic [$clog2(NUM_ARCH)-1:0] wr_a,
  input  logic [$clog2(NUM_PHYS)-1:0] wr_p
);
  localparam int PW = $clog2(NUM_PHYS);

  logic [PW-1:0] map_q [NUM_ARCH];

  assign rd_p1 = map_q[rd_a1];
  assign rd_p2 = map_q[rd_a2];
  assign rd_p3 = map_q[rd_a3];

  genvar g;
  generate
    for (g = 0; g < NUM_ARCH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          map_q[g] <= PW'(g);
        end else if (we && (wr_a == g)) begin
          map_q[g] <= wr_p;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rf_history.sv
// In-flight log: appended at the young end, retired from the old end
// on commit, or unwound from the young end during recovery.
module rf_history #(
  parameter int NUM_ARCH   = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic                          push_has,
  input  logic [$clog2(NUM_ARCH)-1:0]   push_arch,
  input  logic [$clog2(NUM_PHYS)-1:0]   push_new,
  input  logic [$clog2(NUM_PHYS)-1:0]   push_old,
  input  logic                          pop_old,
  input  logic                          pop_young,
  output logic                          old_has,
  output logic [$clog2(NUM_PHYS)-1:0]   old_prev,
  output logic                          young_has,
  output logic [$clog2(NUM_ARCH)-1:0]   young_arch,
  output logic [$clog2(NUM_PHYS)-1:0]   young_new,
  output logic [$clog2(NUM_PHYS)-1:0]   young_prev,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(HIST_DEPTH):0]   count
);
  localparam int AW = $clog2(NUM_ARCH);
  localparam int PW = $clog2(NUM_PHYS);
  localparam int HW = $clog2(HIST_DEPTH);

  logic          e_has  [HIST_DEPTH];
  logic [AW-1:0] e_arch [HIST_DEPTH];
  logic [PW-1:0] e_new  [HIST_DEPTH];
  logic [PW-1:0] e_prev [HIST_DEPTH];

  logic [HW-1:0] old_ptr;
  logic [HW-1:0] tail_ptr;
  logic [HW-1:0] young_ptr;

  assign young_ptr  = tail_ptr - 1'b1;
  assign empty      = (count == '0);
  assign full       = (count == (HW+1)'(HIST_DEPTH));
  assign old_has    = e_has[old_ptr];
  assign old_prev   = e_prev[old_ptr];
  assign young_has  = e_has[young_ptr];
  assign young_arch = e_arch[young_ptr];
  assign young_new  = e_new[young_ptr];
  assign young_prev = e_prev[young_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST_DEPTH; i++) begin
        e_has[i]  <= 1'b0;
        e_arch[i] <= '0;
        e_new[i]  <= '0;
        e_prev[i] <= '0;
      end
      old_ptr  <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (push) begin
        e_has[tail_ptr]  <= push_has;
        e_arch[tail_ptr] <= push_arch;
        e_new[tail_ptr]  <= push_new;
        e_prev[tail_ptr] <= push_old;
        tail_ptr         <= tail_ptr + 1'b1;
      end else if (pop_young) begin
        tail_ptr <= young_ptr;
      end
      if (pop_old) begin
        old_ptr <= old_ptr + 1'b1;
      end
      if (push && !pop_old) begin
        count <= count + 1'b1;
      end else if (!push && (pop_old || pop_young)) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_rename.sv
module rf_rename
  import rf_rename_pkg::*;
#(
  parameter int NUM_ARCH   = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rn_valid,
  output logic                        rn_ready,
  input  logic [$clog2(NUM_ARCH)-1:0] rn_src1,
  input  logic [$clog2(NUM_ARCH)-1:0] rn_src2,
  input  logic                        rn_has_dst,
  input  logic [$clog2(NUM_ARCH)-1:0] rn_dst,
  output logic [$clog2(NUM_PHYS)-1:0] rn_psrc1,
  output logic [$clog2(NUM_PHYS)-1:0] rn_psrc2,
  output logic [$clog2(NUM_PHYS)-1:0] rn_pdst,
  output logic [$clog2(NUM_PHYS)-1:0] rn_pold,
  input  logic                        cmt_valid,
  output logic                        cmt_ready,
  output logic                        cmt_frees,
  output logic [$clog2(NUM_PHYS)-1:0] cmt_old_preg,
  input  logic                        trap,
  output logic                        recover_busy
);
  localparam int AW = $clog2(NUM_ARCH);
  localparam int PW = $clog2(NUM_PHYS);
  localparam int HW = $clog2(HIST_DEPTH);

  rec_state_e rs_q;

  logic [PW-1:0] map_dst_prev;
  logic [PW-1:0] fl_head;
  logic          fl_empty;
  logic [PW:0]   fl_count;
  logic          fl_push;
  logic [PW-1:0] fl_push_preg;

  logic          h_old_has;
  logic [PW-1:0] h_old_prev;
  logic          h_young_has;
  logic [AW-1:0] h_young_arch;
  logic [PW-1:0] h_young_new;
  logic [PW-1:0] h_young_prev;
  logic          h_empty;
  logic          h_full;
  logic [HW:0]   hist_count;

  logic          rn_fire;
  logic          alloc;
  logic          cmt_fire;
  logic          undo;
  logic          map_we;
  logic [AW-1:0] map_wa;
  logic [PW-1:0] map_wp;

  assign recover_busy = (rs_q == RS_UNDO);

  assign rn_ready = !recover_busy && !trap && !h_full && (!rn_has_dst || !fl_empty);
  assign rn_fire  = rn_valid && rn_ready;
  assign alloc    = rn_fire && rn_has_dst;

  assign cmt_ready    = !recover_busy && !trap && !h_empty;
  assign cmt_fire     = cmt_valid && cmt_ready;
  assign cmt_frees    = cmt_ready && h_old_has;
  assign cmt_old_preg = h_old_prev;

  assign undo = recover_busy && !h_empty;

  assign rn_pdst = rn_has_dst ? fl_head : '0;
  assign rn_pold = rn_has_dst ? map_dst_prev : '0;

  // Single table write port: recovery and rename never overlap.
  assign map_we = alloc || (undo && h_young_has);
  assign map_wa = undo ? h_young_arch : rn_dst;
  assign map_wp = undo ? h_young_prev : fl_head;

  // Single free-list push: commit release or undo return.
  assign fl_push      = (cmt_fire && h_old_has) || (undo && h_young_has);
  assign fl_push_preg = undo ? h_young_new : h_old_prev;

  rf_maptable #(
    .NUM_ARCH(NUM_ARCH),
    .NUM_PHYS(NUM_PHYS)
  ) u_map (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_a1(rn_src1),
    .rd_a2(rn_src2),
    .rd_a3(rn_dst),
    .rd_p1(rn_psrc1),
    .rd_p2(rn_psrc2),
    .rd_p3(map_dst_prev),
    .we   (map_we),
    .wr_a (map_wa),
    .wr_p (map_wp)
  );

  rf_freelist #(
    .NUM_ARCH(NUM_ARCH),
    .NUM_PHYS(NUM_PHYS)
  ) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .push     (fl_push),
    .push_preg(fl_push_preg),
    .head_preg(fl_head),
    .empty    (fl_empty),
    .count    (fl_count)
  );

  rf_history #(
    .NUM_ARCH  (NUM_ARCH),
    .NUM_PHYS  (NUM_PHYS),
    .HIST_DEPTH(HIST_DEPTH)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rn_fire),
    .push_has  (rn_has_dst),
    .push_arch (rn_dst),
    .push_new  (rn_pdst),
    .push_old  (rn_pold),
    .pop_old   (cmt_fire),
    .pop_young (undo),
    .old_has   (h_old_has),
    .old_prev  (h_old_prev),
    .young_has (h_young_has),
    .young_arch(h_young_arch),
    .young_new (h_young_new),
    .young_prev(h_young_prev),
    .empty     (h_empty),
    .full      (h_full),
    .count     (hist_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_q <= RS_RUN;
    end else begin
      unique case (rs_q)
        RS_RUN:  if (trap && !h_empty) rs_q <= RS_UNDO;
        RS_UNDO: if (hist_count == (HW+1)'(1)) rs_q <= RS_RUN;
        default: rs_q <= RS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rf_rename_chk.sv
module rf_rename_chk #(
  parameter int NUM_ARCH   = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rn_valid,
  input logic                        rn_ready,
  input logic                        rn_has_dst,
  input logic [$clog2(NUM_PHYS)-1:0] rn_pdst,
  input logic [$clog2(NUM_PHYS)-1:0] rn_pold,
  input logic                        cmt_ready,
  input logic                        recover_busy,
  input logic [$clog2(NUM_PHYS):0]   fl_count,
  input logic [$clog2(HIST_DEPTH):0] hist_count
);
  localparam int NFREE = NUM_PHYS - NUM_ARCH;

  assert_stall_in_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recover_busy |-> (!rn_ready && !cmt_ready));

  assert_fresh_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid && rn_ready && rn_has_dst) |-> (rn_pdst != rn_pold));

  assert_alloc_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid && rn_ready && rn_has_dst) |-> (fl_count != '0));

  assert_walk_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recover_busy) |-> (hist_count == '0));

  assert_free_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= ($clog2(NUM_PHYS)+1)'(NFREE));

  assert_commit_has_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_ready |-> (hist_count != '0));
endmodule

bind rf_rename rf_rename_chk #(
  .NUM_ARCH  (NUM_ARCH),
  .NUM_PHYS  (NUM_PHYS),
  .HIST_DEPTH(HIST_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rn_valid    (rn_valid),
  .rn_ready    (rn_ready),
  .rn_has_dst  (rn_has_dst),
  .rn_pdst     (rn_pdst),
  .rn_pold     (rn_pold),
  .cmt_ready   (cmt_ready),
  .recover_busy(recover_busy),
  .fl_count    (fl_count),
  .hist_count  (hist_count)
);

// File: tb/rf_rename_tb.sv
module rf_rename_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rn_valid = 1'b0;
  logic       rn_ready;
  logic [2:0] rn_src1 = '0;
  logic [2:0] rn_src2 = '0;
  logic       rn_has_dst = 1'b0;
  logic [2:0] rn_dst = '0;
  logic [3:0] rn_psrc1, rn_psrc2, rn_pdst, rn_pold;
  logic       cmt_valid = 1'b0;
  logic       cmt_ready;
  logic       cmt_frees;
  logic [3:0] cmt_old_preg;
  logic       trap = 1'b0;
  logic       recover_busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rf_rename #(.NUM_ARCH(8), .NUM_PHYS(16), .HIST_DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rn_valid(rn_valid), .rn_ready(rn_ready),
    .rn_src1(rn_src1), .rn_src2(rn_src2),
    .rn_has_dst(rn_has_dst), .rn_dst(rn_dst),
    .rn_psrc1(rn_psrc1), .rn_psrc2(rn_psrc2),
    .rn_pdst(rn_pdst), .rn_pold(rn_pold),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready),
    .cmt_frees(cmt_frees), .cmt_old_preg(cmt_old_preg),
    .trap(trap), .recover_busy(recover_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rn_valid = 1'b0; cmt_valid = 1'b0; trap = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // One accepted rename; response sampled before the accepting edge.
  task automatic ren(input int s1, input int s2, input bit hd, input int d,
                     output int p1, output int p2, output int pd, output int po);
    @(negedge clk);
    rn_valid = 1'b1; rn_src1 = 3'(s1); rn_src2 = 3'(s2);
    rn_has_dst = hd; rn_dst = 3'(d);
    #1;
    check("R6 rename accepted", int'(rn_ready), 1);
    p1 = rn_psrc1; p2 = rn_psrc2; pd = rn_pdst; po = rn_pold;
    @(posedge clk);
    #1;
    rn_valid = 1'b0;
  endtask

  task automatic cmt(output int rdy, output int fr, output int old);
    @(negedge clk);
    cmt_valid = 1'b1;
    #1;
    rdy = cmt_ready; fr = cmt_frees; old = cmt_old_preg;
    @(posedge clk);
    #1;
    cmt_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rn_ready", int'(rn_ready), 1);
    check("R1 cmt_ready", int'(cmt_ready), 0);
    check("R1 recover_busy", int'(recover_busy), 0);
  endtask

  task automatic t_basic();
    int p1, p2, pd, po;
    do_reset();
    ren(1, 2, 1, 3, p1, p2, pd, po);
    check("R1 identity src1", p1, 1);
    check("R2 src2", p2, 2);
    check("R3 first alloc", pd, 8);
    check("R4 prior map", po, 3);
    ren(3, 4, 1, 3, p1, p2, pd, po);
    check("R2 src sees own old map", p1, 8);
    check("R3 second alloc", pd, 9);
    check("R4 prior map chained", po, 8);
    ren(3, 3, 0, 0, p1, p2, pd, po);
    check("R3 later reader", p1, 9);
    ren(5, 0, 1, 5, p1, p2, pd, po);
    check("R5 no-dst took nothing", pd, 10);
    check("R5 table unchanged", p2, 0);
  endtask

  task automatic t_commit();
    int p1, p2, pd, po, rdy, fr, old;
    do_reset();
    ren(0, 0, 1, 1, p1, p2, pd, po);
    ren(0, 0, 0, 0, p1, p2, pd, po);
    ren(0, 0, 1, 1, p1, p2, pd, po);
    cmt(rdy, fr, old);
    check("R7 commit ready", rdy, 1);
    check("R7 frees", fr, 1);
    check("R7 old preg oldest", old, 1);
    cmt(rdy, fr, old);
    check("R5 no-dst frees nothing", fr, 0);
    cmt(rdy, fr, old);
    check("R7 old preg third", old, 8);
    #1;
    check("R7 nothing in flight", int'(cmt_ready), 0);
    for (int i = 0; i < 6; i++) ren(0, 0, 1, 2, p1, p2, pd, po);
    ren(0, 0, 1, 2, p1, p2, pd, po);
    check("R7 freed reg appended 1", pd, 1);
    ren(0, 0, 1, 2, p1, p2, pd, po);
    check("R7 freed reg appended 2", pd, 8);
  endtask

  task automatic t_empty();
    int p1, p2, pd, po, rdy, fr, old;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      ren(0, 0, 1, 7, p1, p2, pd, po);
      check("R3 drain order", pd, 8 + i);
    end
    @(negedge clk);
    rn_valid = 1'b1; rn_has_dst = 1'b1;
    #1;
    check("R6 stall on empty", int'(rn_ready), 0);
    rn_has_dst = 1'b0;
    #1;
    check("R6 no-dst passes empty", int'(rn_ready), 1);
    rn_valid = 1'b0;
    cmt(rdy, fr, old);
    check("R7 first release", old, 7);
    ren(0, 0, 1, 6, p1, p2, pd, po);
    check("R7 released reg reused", pd, 7);
  endtask

  task automatic t_trap();
    int p1, p2, pd, po, n;
    do_reset();
    ren(0, 0, 1, 1, p1, p2, pd, po);
    ren(0, 0, 1, 2, p1, p2, pd, po);
    ren(0, 0, 0, 0, p1, p2, pd, po);
    ren(0, 0, 1, 1, p1, p2, pd, po);
    @(negedge clk);
    trap = 1'b1;
    #1;
    check("R6 ready low on trap", int'(rn_ready), 0);
    @(posedge clk);
    #1;
    trap = 1'b0;
    n = 0;
    while (recover_busy && n < 50) begin
      if (n == 0) begin
        check("R10 no rename in recovery", int'(rn_ready), 0);
        check("R10 no commit in recovery", int'(cmt_ready), 0);
      end
      @(posedge clk);
      #1;
      n++;
    end
    check("R8 walk length", n, 4);
    ren(1, 2, 0, 0, p1, p2, pd, po);
    check("R8 restored x1", p1, 1);
    check("R8 restored x2", p2, 2);
    for (int i = 0; i < 5; i++) ren(0, 0, 1, 3, p1, p2, pd, po);
    ren(0, 0, 1, 3, p1, p2, pd, po);
    check("R9 youngest returned first", pd, 10);
    ren(0, 0, 1, 3, p1, p2, pd, po);
    check("R9 then next", pd, 9);
    ren(0, 0, 1, 3, p1, p2, pd, po);
    check("R9 then oldest", pd, 8);
    @(negedge clk);
    do_reset();
    @(negedge clk);
    trap = 1'b1;
    @(posedge clk);
    #1;
    trap = 1'b0;
    check("R8 empty trap no walk", int'(recover_busy), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_commit();
    t_empty();
    t_trap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule